// File: doc/BRIEF.md
# Clock Synthesizer Configuration Port

This block keeps the divider and test-select settings of a clock synthesizer: a 7-bit feedback divide value (M), a 2-bit output divide code (N) and a 3-bit test-select code (T). M and N can come straight from parallel pins. Alternatively, all three fields can be written through a three-wire serial interface made of a serial clock, serial data and a load strobe.

The serial interface and the parallel-mode select are sampled on the block clock. These inputs are expected to be synchronous to that clock already.

When the parallel-mode select `par_load_n_i` is low, the block is in parallel mode. In that mode the holding registers follow the M and N pins, the test field is held at zero, and the serial shift register is frozen. When the select is high, serial mode is active. Each rising edge of the serial clock shifts one data bit into a 12-bit register. A falling edge of the load strobe then copies the three fields into the holding registers. The most significant bit of the shift register is brought out, so that a downstream test multiplexer can observe the stream.

Top module: `syncfg_port`

## Requirements
- R1: After reset, `m_o`, `n_o`, `t_o` and `sout_o` are all zero.
- R2: While `par_load_n_i` is high, each rising edge of `sclk_i` shifts `sdata_i` into bit 0 of the 12-bit shift register. The older bits move one place up. `sout_o` is bit 11 of that register, which is the bit shifted in 12 rising edges earlier. The result is visible one clock after the edge is sampled.
- R3: Field placement in the shift register is T = bits 11:9, N = bits 8:7 and M = bits 6:0. As a result, a stream sent MSB first within each field, in the order T, N, M, lands each field in its own slot.
- R4: While `par_load_n_i` is low, edges on `sclk_i` leave the shift register and `sout_o` unchanged.
- R5: While `par_load_n_i` is high, a falling edge of `sload_i` copies the shift register fields into `t_o`, `n_o` and `m_o` one clock later.
- R6: While `par_load_n_i` is low, `m_o` and `n_o` take the values of `m_par_i` and `n_par_i` one clock later. A falling edge of `sload_i` in that mode is ignored.
- R7: While `par_load_n_i` is low, `t_o` is forced to 000 one clock later. The test field has no parallel input.
- R8: While `par_load_n_i` is high and no falling edge of `sload_i` occurs, `m_o`, `n_o` and `t_o` hold their values. This includes the cycles with a rising edge of `sload_i` and any serial shifting.
- R9: A falling edge or a steady level on `sclk_i` does not shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_load_n_i | input | 1 | Low: parallel mode; high: serial mode |
| m_par_i | input | 7 | Parallel M divide value |
| n_par_i | input | 2 | Parallel N divide code |
| sclk_i | input | 1 | Serial clock, shifts on rising edge |
| sdata_i | input | 1 | Serial data |
| sload_i | input | 1 | Serial load strobe, acts on falling edge |
| m_o | output | 7 | Held M divide value |
| n_o | output | 2 | Held N divide code |
| t_o | output | 3 | Held test-select code |
| sout_o | output | 1 | Shift register MSB |

## Verification
The assertions check on every cycle the properties that need only one cycle of history:
- the test field is safe in parallel mode;
- M and N track the pins;
- the shift register freezes in parallel mode and whenever no serial clock rise occurs;
- the holding registers stay put without a strobe fall.

The following can only be shown by the bench's scenarios, because they depend on a whole 12-bit history:
- the field order of a full serial stream;
- the delay of 12 rising edges before a bit reaches `sout_o`;
- the correctness of the values copied on the strobe.

// File: rtl/syncfg_pkg.sv
package syncfg_pkg;
  parameter int unsigned M_W_DEF = 7;
  parameter int unsigned N_W_DEF = 2;
  parameter int unsigned T_W_DEF = 3;

  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } cfg_mode_e;
endpackage

// File: rtl/syncfg_edge.sv
module syncfg_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= RST_VAL;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/syncfg_shift.sv
module syncfg_shift #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] word_o,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[W-2:0], din_i};
  end

  assign word_o = sr_q;
  assign msb_o  = sr_q[W-1];
endmodule

// File: rtl/syncfg_hold.sv
module syncfg_hold
  import syncfg_pkg::*;
#(
  parameter int unsigned M_W = M_W_DEF,
  parameter int unsigned N_W = N_W_DEF,
  parameter int unsigned T_W = T_W_DEF,
  localparam int unsigned SR_W = M_W + N_W + T_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cfg_mode_e       mode_i,
  input  logic            strobe_i,
  input  logic [M_W-1:0]  m_par_i,
  input  logic [N_W-1:0]  n_par_i,
  input  logic [SR_W-1:0] word_i,
  output logic [M_W-1:0]  m_o,
  output logic [N_W-1:0]  n_o,
  output logic [T_W-1:0]  t_o
);
  localparam int unsigned N_LSB = M_W;
  localparam int unsigned T_LSB = M_W + N_W;

  logic [M_W-1:0] m_q;
  logic [N_W-1:0] n_q;
  logic [T_W-1:0] t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (mode_i == MODE_PAR) begin
      m_q <= m_par_i;
      n_q <= n_par_i;
      t_q <= '0;  // quiet test output while pins drive config
    end else if (strobe_i) begin
      m_q <= word_i[M_W-1:0];
      n_q <= word_i[N_LSB +: N_W];
      t_q <= word_i[T_LSB +: T_W];
    end
  end

  assign m_o = m_q;
  assign n_o = n_q;
  assign t_o = t_q;
endmodule

// File: rtl/syncfg_port.sv
module syncfg_port
  import syncfg_pkg::*;
#(
  parameter int unsigned M_W = M_W_DEF,
  parameter int unsigned N_W = N_W_DEF,
  parameter int unsigned T_W = T_W_DEF,
  localparam int unsigned SR_W = M_W + N_W + T_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_load_n_i,
  input  logic [M_W-1:0] m_par_i,
  input  logic [N_W-1:0] n_par_i,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           sload_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           sout_o
);
  cfg_mode_e       mode;
  logic            sclk_rise, sclk_fall;
  logic            sload_rise, sload_fall;
  logic [SR_W-1:0] word;

  assign mode = par_load_n_i ? MODE_SER : MODE_PAR;

  // reset to 1 so a clock already high out of reset is not a rise
  syncfg_edge #(.RST_VAL(1'b1)) u_sclk_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sclk_i),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  syncfg_edge #(.RST_VAL(1'b0)) u_sload_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sload_i),
    .rise_o (sload_rise),
    .fall_o (sload_fall)
  );

  syncfg_shift #(.W(SR_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sclk_rise && mode == MODE_SER),
    .din_i  (sdata_i),
    .word_o (word),
    .msb_o  (sout_o)
  );

  syncfg_hold #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .strobe_i (sload_fall),
    .m_par_i  (m_par_i),
    .n_par_i  (n_par_i),
    .word_i   (word),
    .m_o      (m_o),
    .n_o      (n_o),
    .t_o      (t_o)
  );

  logic unused_edges;
  assign unused_edges = sclk_fall | sload_rise;
endmodule

// File: rtl/syncfg_port_chk.sv
module syncfg_port_chk #(
  parameter int unsigned M_W = 7,
  parameter int unsigned N_W = 2,
  parameter int unsigned T_W = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           par_load_n_i,
  input logic [M_W-1:0] m_par_i,
  input logic [N_W-1:0] n_par_i,
  input logic           sclk_i,
  input logic           sload_i,
  input logic [M_W-1:0] m_o,
  input logic [N_W-1:0] n_o,
  input logic [T_W-1:0] t_o,
  input logic           sout_o
);
  logic was_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) was_rst <= 1'b0;
    else         was_rst <= 1'b1;
  end

  // R7
  a_r7_test_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_load_n_i |=> t_o == '0);

  // R6
  a_r6_par_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (was_rst && !par_load_n_i) |=> (m_o == $past(m_par_i) && n_o == $past(n_par_i)));

  // R4
  a_r4_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (was_rst && !par_load_n_i) |=> $stable(sout_o));

  // R9
  a_r9_no_rise_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (was_rst && !$rose(sclk_i)) |=> $stable(sout_o));

  // R8
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (was_rst && par_load_n_i && !$fell(sload_i)) |=>
      ($stable(m_o) && $stable(n_o) && $stable(t_o)));
endmodule

bind syncfg_port syncfg_port_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .par_load_n_i (par_load_n_i),
  .m_par_i      (m_par_i),
  .n_par_i      (n_par_i),
  .sclk_i       (sclk_i),
  .sload_i      (sload_i),
  .m_o          (m_o),
  .n_o          (n_o),
  .t_o          (t_o),
  .sout_o       (sout_o)
);

// File: tb/sim_syncfg_port.sv
module sim_syncfg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_n = 1'b0;
  logic [6:0] m_par = '0;
  logic [1:0] n_par = '0;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       sload = 1'b0;
  logic [6:0] m_o;
  logic [1:0] n_o;
  logic [2:0] t_o;
  logic       sout_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [11:0] esr = '0;
  logic [6:0]  em = '0;
  logic [1:0]  en = '0;
  logic [2:0]  et = '0;

  always #4 clk = ~clk;

  syncfg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .par_load_n_i(par_n),
    .m_par_i(m_par), .n_par_i(n_par), .sclk_i(sclk), .sdata_i(sdata),
    .sload_i(sload), .m_o(m_o), .n_o(n_o), .t_o(t_o), .sout_o(sout_o)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " m"}, 32'(m_o), 32'(em));
    chk({req, " n"}, 32'(n_o), 32'(en));
    chk({req, " t"}, 32'(t_o), 32'(et));
    chk({req, " sout"}, 32'(sout_o), 32'(esr[11]));
  endtask

  function automatic logic [11:0] pack_word(logic [2:0] t, logic [1:0] n, logic [6:0] m);
    return {t, n, m};  // R3 field slots
  endfunction

  task automatic shift_bit(bit b);
    sdata = b;
    tick(1);
    sclk = 1'b1;
    tick(1);
    if (par_n) esr = {esr[10:0], b};
    sclk = 1'b0;  // falling edge, no shift (R9)
    tick(1);
  endtask

  task automatic shift_word(logic [11:0] w);
    for (int i = 11; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic strobe();
    sload = 1'b1;
    tick(1);
    sload = 1'b0;
    tick(1);
    if (par_n) begin
      em = esr[6:0];
      en = esr[8:7];
      et = esr[11:9];
    end
  endtask

  task automatic par_set(logic [6:0] m, logic [1:0] n);
    par_n = 1'b0;
    m_par = m;
    n_par = n;
    tick(1);
    em = m;
    en = n;
    et = '0;
  endtask

  initial begin
    tick(3);
    chk_all("R1 reset");
    rst_n = 1'b1;
    par_n = 1'b1;
    tick(2);
    chk_all("R1 after release");

    // R2: sout shows bit shifted 12 edges earlier
    shift_bit(1'b1);
    for (int i = 0; i < 10; i++) shift_bit(1'b0);
    chk("R2 not yet out", 32'(sout_o), 32'd0);
    shift_bit(1'b0);
    chk("R2 out after 12", 32'(sout_o), 32'd1);

    // R3/R5 directed stream
    shift_word(pack_word(3'b101, 2'b10, 7'h5A));
    chk("R3 sout T2", 32'(sout_o), 32'd1);
    chk_all("R8 before strobe");
    sload = 1'b1;
    tick(2);
    chk_all("R8 sload rise ignored");
    sload = 1'b0;
    tick(1);
    em = 7'h5A; en = 2'b10; et = 3'b101;
    chk_all("R5 strobe fields");
    chk("R3 t", 32'(t_o), 32'd5);
    chk("R3 n", 32'(n_o), 32'd2);
    chk("R3 m", 32'(m_o), 32'h5A);

    // R8: shifting alone keeps held values
    shift_word(12'h3C7);
    chk_all("R8 shift no strobe");

    // R9: sclk held high, no extra shift
    sclk = 1'b1;
    tick(1);
    esr = {esr[10:0], sdata};
    tick(5);
    sdata = ~sdata;
    tick(3);
    sclk = 1'b0;
    tick(3);
    chk_all("R9 steady level");

    // R6/R7 parallel mode
    par_set(7'h7F, 2'b11);
    chk_all("R6 R7 parallel");
    par_set(7'h01, 2'b00);
    chk_all("R6 parallel change");
    // R4: serial edges frozen
    shift_word(12'hFFF);
    chk_all("R4 frozen");
    // R6: strobe ignored in parallel
    strobe();
    chk_all("R6 strobe ignored");
    par_n = 1'b1;
    tick(2);
    chk_all("R8 after leaving parallel");

    // random mix
    for (int k = 0; k < 60; k++) begin
      int unsigned r = $urandom();
      if (r[1:0] == 2'd0) begin
        par_set(7'($urandom()), 2'($urandom()));
        if (r[2]) shift_bit(1'($urandom()));
        chk_all("R6 R7 R4 random parallel");
        par_n = 1'b1;
        tick(1);
      end else begin
        shift_word(12'($urandom()));
        chk_all("R2 R8 random shift");
        strobe();
        chk_all("R5 R3 random strobe");
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule